// File: doc/BRIEF.md
# Four-Entry Translation Cache with Page Allocator

This block turns a 32-bit virtual address into a physical address. Pages are 4 KB, so the low 12 bits pass through unchanged and the upper 20 bits form the virtual page number. Recent translations sit in a four-entry, fully associative translation cache. Every entry's tag is compared with the incoming page number at the same time.

When the cache misses, the block reads a small internal page table, indexed by the low bits of the virtual page number. A valid table entry is copied into the cache. An invalid entry is a page fault. The block then takes the physical page one above the highest page handed out so far, records it in the page table and in the cache, and reports the fault. Cache refills go to empty slots first. Once the cache is full, the least recently used entry is replaced.

Software loads the page table and the starting highest page number through a configuration port after reset and before any requests are sent. Requests use a valid/ready handshake. Each response is a one-cycle pulse carrying three flags: cache hit, table hit and fault.

Top module: `vtrans_unit`

## Requirements
- R1: The response address is the translated 8-bit physical page number in bits [19:12] and the request's untouched offset in bits [11:0].
- R2: A request whose page is in the cache gets its response one cycle after acceptance, with cache hit set and the other two flags clear. A page is held in at most one cache entry.
- R3: A cache miss on a page whose table entry is valid gets its response two cycles after acceptance, with only the table-hit flag set and the table's page number. No page is allocated.
- R4: A miss on a page whose table entry is invalid gets its response three cycles after acceptance, with only the fault flag set. The page number returned is the current highest page plus one, and the highest page advances by one.
- R5: A fault marks the page-table entry valid with the new page number, so a later miss on that page is a table hit with the same number.
- R6: Refills fill empty cache entries before any valid entry is evicted, so four distinct pages can be cached after reset without losing any of them.
- R7: When the cache is full, a refill replaces the entry whose last hit or refill is oldest. A hit counts as a use.
- R8: The ready output is high when the block is idle and low while a miss or fault is being handled.
- R9: Synchronous active-high reset empties the cache, clears every page-table valid bit and clears any pending response.
- R10: Writing the starting highest page number through the configuration port sets the base, so the next fault returns that value plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pt_we | input | 1 | Page-table entry write strobe |
| cfg_pt_idx | input | 4 | Page-table entry index (low virtual page number bits) |
| cfg_pt_vld | input | 1 | Valid bit to write |
| cfg_pt_ppn | input | 8 | Physical page number to write |
| cfg_top_we | input | 1 | Highest-page-number write strobe |
| cfg_top_ppn | input | 8 | Starting highest physical page number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 20 | Physical address |
| rsp_tlb_hit | output | 1 | Served from the translation cache |
| rsp_pt_hit | output | 1 | Served from the page table |
| rsp_fault | output | 1 | Page fault: a new page was allocated |

## Verification
The bench fills all four cache entries and then checks that the first-cached page still hits. A design that evicted before the cache was full would miss there. It then checks that a hit in the middle of the sequence changes which page is evicted next. A design with wrong recency updates would evict the refreshed page and later report a table hit where a cache hit is expected. The bench also re-reads pages that faulted after they have left the cache. A design that did not write the allocation back to the page table would fault again and hand out a fresh page number. Finally, it checks the latency of each response path and that ready stays low during table walks, and it reloads the highest page number to show that allocation starts from the new base.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = 8;
    localparam int PA_W     = PPN_W + OFF_W;
    localparam int TLB_N    = 4;
    localparam int IDX_W    = $clog2(TLB_N);
    localparam int PT_DEPTH = 16;
    localparam int PT_IW    = $clog2(PT_DEPTH);

    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_ALLOC} xl_state_e;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    typedef struct packed {
        logic             vld;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic            tlb_hit;
        logic            pt_hit;
        logic            fault;
        logic [PA_W-1:0] pa;
    } xl_rsp_t;

    function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0]  va);
        return {ppn, va[OFF_W-1:0]};
    endfunction

    function automatic logic [PT_IW-1:0] pt_index(input logic [VA_W-1:0] va);
        return va[OFF_W +: PT_IW];
    endfunction
endpackage

// File: rtl/tlb_age.sv
module tlb_age
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);
    logic [IDX_W-1:0] age_q [TLB_N];
    logic [IDX_W-1:0] touch_age;

    assign touch_age = age_q[touch_idx];

    for (genvar i = 0; i < TLB_N; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[i] <= IDX_W'(i);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < touch_age)
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < TLB_N; i++)
            if (age_q[i] == IDX_W'(TLB_N - 1)) oldest_idx = IDX_W'(i);
    end

    logic [TLB_N-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int i = 0; i < TLB_N; i++) age_seen[age_q[i]] = 1'b1;
    end

    // R7
    age_perm_chk: assert property (@(posedge clk) disable iff (rst)
        age_seen == {TLB_N{1'b1}});

    // R7
    touch_young_chk: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic [IDX_W-1:0] oldest_idx,
    output logic [IDX_W-1:0] victim_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    tlb_ent_t         ent_q [TLB_N];
    logic [TLB_N-1:0] match;

    for (genvar i = 0; i < TLB_N; i++) begin : g_ent
        assign match[i] = ent_q[i].vld && (ent_q[i].vpn == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst)
                ent_q[i].vld <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(i))
                ent_q[i] <= '{vld: 1'b1, vpn: wr_vpn, ppn: wr_ppn};
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < TLB_N; i++)
            if (match[i]) hit_idx = IDX_W'(i);
    end

    assign hit     = |match;
    assign hit_ppn = ent_q[hit_idx].ppn;

    always_comb begin
        victim_idx = oldest_idx;
        for (int i = TLB_N - 1; i >= 0; i--)
            if (!ent_q[i].vld) victim_idx = IDX_W'(i);
    end

    // R2
    one_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
endmodule

// File: rtl/page_store.sv
module page_store
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [PT_IW-1:0] cfg_idx,
    input  pte_t             cfg_pte,
    input  logic             top_we,
    input  logic [PPN_W-1:0] top_val,
    input  logic [PT_IW-1:0] rd_idx,
    output pte_t             rd_pte,
    input  logic             alloc_en,
    output logic [PPN_W-1:0] alloc_ppn
);
    pte_t             pt_q [PT_DEPTH];
    logic [PPN_W-1:0] top_q;

    assign alloc_ppn = top_q + 1'b1;
    assign rd_pte    = pt_q[rd_idx];

    for (genvar i = 0; i < PT_DEPTH; i++) begin : g_pte
        always_ff @(posedge clk) begin
            if (rst)
                pt_q[i] <= '0;
            else if (alloc_en && rd_idx == PT_IW'(i))
                pt_q[i] <= '{vld: 1'b1, ppn: alloc_ppn};
            else if (cfg_we && cfg_idx == PT_IW'(i))
                pt_q[i] <= cfg_pte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           top_q <= '0;
        else if (alloc_en) top_q <= alloc_ppn;
        else if (top_we)   top_q <= top_val;
    end

    // R4
    top_step_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> top_q == $past(top_q) + 1'b1);

    // R5
    alloc_mark_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> pt_q[$past(rd_idx)].vld && pt_q[$past(rd_idx)].ppn == top_q);
endmodule

// File: rtl/vtrans_unit.sv
module vtrans_unit
    import xlat_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_pt_we,
    input  logic [PT_IW-1:0]         cfg_pt_idx,
    input  logic                     cfg_pt_vld,
    input  logic [PPN_W-1:0]         cfg_pt_ppn,
    input  logic                     cfg_top_we,
    input  logic [PPN_W-1:0]         cfg_top_ppn,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_va,
    output logic                     rsp_valid,
    output logic [PA_W-1:0]          rsp_pa,
    output logic                     rsp_tlb_hit,
    output logic                     rsp_pt_hit,
    output logic                     rsp_fault
);
    xl_state_e        state_q;
    logic [VA_W-1:0]  va_q;
    xl_rsp_t          rsp_q;
    logic             rsp_vld_q;

    logic             hit;
    logic [IDX_W-1:0] hit_idx, victim_idx, oldest_idx, touch_idx;
    logic [PPN_W-1:0] hit_ppn, alloc_ppn, fill_ppn;
    pte_t             rd_pte;
    logic             accept, walk_fill, alloc_en, fill_en, touch_en;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign walk_fill = (state_q == ST_WALK) && rd_pte.vld;
    assign alloc_en  = (state_q == ST_ALLOC);
    assign fill_en   = walk_fill || alloc_en;
    assign fill_ppn  = alloc_en ? alloc_ppn : rd_pte.ppn;
    assign touch_en  = (accept && hit) || fill_en;
    assign touch_idx = fill_en ? victim_idx : hit_idx;

    tlb_store u_store (
        .clk        (clk),
        .rst        (rst),
        .lk_vpn     (req_va[VA_W-1:OFF_W]),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_ppn    (hit_ppn),
        .oldest_idx (oldest_idx),
        .victim_idx (victim_idx),
        .wr_en      (fill_en),
        .wr_idx     (victim_idx),
        .wr_vpn     (va_q[VA_W-1:OFF_W]),
        .wr_ppn     (fill_ppn)
    );

    tlb_age u_age (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .oldest_idx (oldest_idx)
    );

    page_store u_pt (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_pt_we),
        .cfg_idx   (cfg_pt_idx),
        .cfg_pte   ('{vld: cfg_pt_vld, ppn: cfg_pt_ppn}),
        .top_we    (cfg_top_we),
        .top_val   (cfg_top_ppn),
        .rd_idx    (pt_index(va_q)),
        .rd_pte    (rd_pte),
        .alloc_en  (alloc_en),
        .alloc_ppn (alloc_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            va_q      <= '0;
            rsp_vld_q <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_vld_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    va_q <= req_va;
                    if (hit) begin
                        rsp_vld_q <= 1'b1;
                        rsp_q     <= '{tlb_hit: 1'b1, pt_hit: 1'b0, fault: 1'b0,
                                       pa: make_pa(hit_ppn, req_va)};
                    end else begin
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: if (rd_pte.vld) begin
                    rsp_vld_q <= 1'b1;
                    rsp_q     <= '{tlb_hit: 1'b0, pt_hit: 1'b1, fault: 1'b0,
                                   pa: make_pa(rd_pte.ppn, va_q)};
                    state_q   <= ST_IDLE;
                end else begin
                    state_q <= ST_ALLOC;
                end
                ST_ALLOC: begin
                    rsp_vld_q <= 1'b1;
                    rsp_q     <= '{tlb_hit: 1'b0, pt_hit: 1'b0, fault: 1'b1,
                                   pa: make_pa(alloc_ppn, va_q)};
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid   = rsp_vld_q;
    assign rsp_pa      = rsp_q.pa;
    assign rsp_tlb_hit = rsp_q.tlb_hit;
    assign rsp_pt_hit  = rsp_q.pt_hit;
    assign rsp_fault   = rsp_q.fault;

    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> rsp_valid && rsp_tlb_hit);

    // R1
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]));

    // R3
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_tlb_hit, rsp_pt_hit, rsp_fault}) == 1);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> !req_ready);
endmodule

// File: tb/vtrans_unit_tb.sv
`timescale 1ns/1ps
module vtrans_unit_tb;
    import xlat_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_pt_we = 1'b0;
    logic [PT_IW-1:0] cfg_pt_idx = '0;
    logic             cfg_pt_vld = 1'b0;
    logic [PPN_W-1:0] cfg_pt_ppn = '0;
    logic             cfg_top_we = 1'b0;
    logic [PPN_W-1:0] cfg_top_ppn = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_va = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_pa;
    logic             rsp_tlb_hit, rsp_pt_hit, rsp_fault;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vtrans_unit u_dut (.*);

    // kind: 0 = cache hit (R2), 1 = table hit (R3), 2 = fault (R4)
    localparam int NV = 16;
    localparam logic [31:0] V_VA [NV] = '{
        32'h0000_0ABC, 32'h0000_0123, 32'h0000_1FFF, 32'h0000_3004,
        32'h0000_3FF0, 32'h0000_4000, 32'h0000_0010, 32'h0000_2222,
        32'h0000_0777, 32'h0000_1000, 32'h0000_3ABC, 32'h0000_4001,
        32'h0000_5000, 32'h0000_1ABC, 32'h0000_0000, 32'h0000_4FFF};
    localparam logic [1:0] V_KIND [NV] = '{
        2'd1, 2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0, 2'd1,
        2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0};
    localparam logic [7:0] V_PPN [NV] = '{
        8'd5, 8'd5, 8'd12, 8'd13, 8'd13, 8'd14, 8'd5, 8'd3,
        8'd5, 8'd12, 8'd13, 8'd14, 8'd15, 8'd12, 8'd5, 8'd14};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pt_write(input int idx, input bit vld, input logic [7:0] ppn);
        @(negedge clk);
        cfg_pt_we = 1'b1; cfg_pt_idx = PT_IW'(idx);
        cfg_pt_vld = vld; cfg_pt_ppn = ppn;
        @(negedge clk);
        cfg_pt_we = 1'b0;
    endtask

    task automatic top_write(input logic [7:0] v);
        @(negedge clk);
        cfg_top_we = 1'b1; cfg_top_ppn = v;
        @(negedge clk);
        cfg_top_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic xlat(input logic [31:0] va, input logic [1:0] kind,
                        input logic [7:0] ppn, input string tag);
        int lat;
        int exp_lat;
        exp_lat = int'(kind) + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            // R8: busy while the walk or allocation runs
            if (lat == 1)
                chk(req_ready == 1'b0, {"R8 busy ", tag}, 32'(req_ready), 32'd0);
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, {"latency ", tag}, 32'(lat), 32'(exp_lat));
        chk({rsp_tlb_hit, rsp_pt_hit, rsp_fault} == (3'b100 >> kind),
            {"flags ", tag}, {29'd0, rsp_tlb_hit, rsp_pt_hit, rsp_fault},
            32'(3'b100 >> kind));
        // R1: page number above, offset below
        chk(rsp_pa == {ppn, va[11:0]}, {"R1 pa ", tag}, 32'(rsp_pa),
            32'({ppn, va[11:0]}));
        // R8: idle again when the response appears
        chk(req_ready == 1'b1, {"R8 idle ", tag}, 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R9 no response after reset", 32'(rsp_valid), 32'd0);

        pt_write(0, 1'b1, 8'd5);
        pt_write(1, 1'b1, 8'd12);
        pt_write(2, 1'b1, 8'd3);
        top_write(8'd12);   // R10

        // Table walk: R2 hits, R3 table hits, R4 faults, R5 reuse after fault,
        // R6 vector 6 still hits after four fills, R7 vectors 7-15 follow recency
        for (int k = 0; k < NV; k++) begin
            string tag;
            case (V_KIND[k])
                2'd0:    tag = $sformatf("R2 hit v%0d", k);
                2'd1:    tag = (k == 10 || k == 11) ? $sformatf("R5 reuse v%0d", k)
                                                    : $sformatf("R3 walk v%0d", k);
                default: tag = $sformatf("R4 fault v%0d", k);
            endcase
            if (k == 6) tag = {tag, " R6"};
            if (k >= 7) tag = {tag, " R7"};
            xlat(V_VA[k], V_KIND[k], V_PPN[k], tag);
        end

        // R9: reset empties cache and page table
        do_reset();
        xlat(32'h0000_0ABC, 2'd2, 8'd1, "R9 table cleared");
        pt_write(0, 1'b1, 8'd5);
        do_reset();
        pt_write(0, 1'b1, 8'd5);
        top_write(8'd12);
        xlat(32'h0000_0ABC, 2'd1, 8'd5, "R9 cache empty");

        // R10: base load sets the next allocation
        xlat(32'h0000_7123, 2'd2, 8'd13, "R10 base 12");
        top_write(8'h40);
        xlat(32'h0000_8FFF, 2'd2, 8'h41, "R10 base 40");
        xlat(32'h0000_8001, 2'd0, 8'h41, "R2 hit after fault");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule